// File: doc/BRIEF.md
# Quick-Channel Trigger Word Event Mapper

This block sits beside a parameter RAM and watches the register-bus writes that go into it. Each of eight quick channels owns a map register that names one parameter slot and one 32-bit word inside that slot. When software writes that word and the channel is enabled, the block issues a transfer event for the channel to a downstream transfer engine. Software can arm a transfer simply by writing the last field of a parameter set, with no separate request line.

Every channel has three one-bit state flags: an enable, an in-flight (secondary) flag and a missed-event flag. An issued event stays in flight until the engine acknowledges it. A trigger write that arrives while the channel is still in flight is recorded as missed and produces no second event. The request to the engine is one-hot, and the lowest-numbered in-flight channel is presented first. The parameter RAM itself, the transfer engine and any interrupt logic lie outside this block.

Top module: `qch_trigger_mapper`

## Requirements
- R1: After reset every map register, the enable mask, the in-flight mask, the missed mask and `evt_req` are all zero.
- R2: The map register of channel c is at byte address 0x0100 + 4*c. It holds the slot number in data bits [13:5] and the word index in bits [4:2]. A bus write to byte address 0x4000 + 32*slot + 4*word hits that channel. The slot region spans 0x4000 to 0x7FFF.
- R3: A write to 0x0120 sets the enable bit of each channel whose data bit is 1. A write to 0x0124 clears the enable bit of each such channel. Channels whose data bit is 0 keep their enable bit.
- R4: A hit on a channel whose enable bit is 0 changes neither the in-flight mask, the missed mask nor `evt_req`.
- R5: A hit on an enabled channel whose in-flight bit is 0 sets that bit at the next clock edge. `evt_req` is always zero or one-hot, and it names the lowest-numbered in-flight channel.
- R6: When `evt_ack` is high on a clock edge, the channel named by `evt_req` loses its in-flight bit at that edge. The next in-flight channel, if there is one, is then requested.
- R7: A hit on an enabled channel whose in-flight bit is already 1 sets that channel's missed bit and issues no further event.
- R8: A write to 0x0128 clears the in-flight bit of every channel whose data bit is 1. A write to 0x012C does the same for the missed bits. A missed bit never clears otherwise.
- R9: A channel whose map register holds zero is detached, so a write to slot 0 word 0 raises no event for it.
- R10: Writes to another word of the mapped slot, to another slot, or outside the slot region raise no event.
- R11: Several enabled channels that map the same word all go in flight from a single write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 16 | Byte address of the bus write |
| wr_data | input | 32 | Bus write data |
| evt_ack | input | 1 | Engine accepts the request currently shown on `evt_req` |
| evt_req | output | 8 | One-hot event request to the transfer engine |
| en_mask | output | 8 | Per-channel event enable state |
| sec_mask | output | 8 | Per-channel in-flight state |
| miss_mask | output | 8 | Per-channel missed-event state |

## Verification
A corrupt map register shows up as a missing or stray event one cycle after a trigger write. It also shows up as a wrong `sec_mask` bit on the cycle after that write, so each map is checked by writing both its own word and its neighbours. A stuck or wrongly cleared flag is visible directly on the mask outputs one cycle after the write or acknowledge that should have changed it. Because `evt_req` is derived from the in-flight flags, a priority error shows on the first cycle in which two channels are in flight at once. The stimulus therefore includes such overlaps, back-to-back acknowledges and repeated triggers to exercise the missed path.

// File: rtl/qtm_pkg.sv
package qtm_pkg;
   // control register offsets, relative to the control base
   localparam int unsigned OFS_MAP0     = 32'h00;
   localparam int unsigned OFS_EN_SET   = 32'h20;
   localparam int unsigned OFS_EN_CLR   = 32'h24;
   localparam int unsigned OFS_SEC_CLR  = 32'h28;
   localparam int unsigned OFS_MISS_CLR = 32'h2C;
   // byte-lane bits below the word index
   localparam int unsigned WORD_LSB     = 2;
endpackage

// File: rtl/qtm_map_regs.sv
module qtm_map_regs #(
   parameter int NUM_CH = 8,
   parameter int KEY_W  = 12
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_CH-1:0]              we,
   input  logic [KEY_W-1:0]               wkey,
   output logic [NUM_CH-1:0][KEY_W-1:0]   map_q
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_map
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     map_q[c] <= '0;
         else if (we[c]) map_q[c] <= wkey;
      end

      // R2: a map only changes on its own write
      a_r2_map_hold : assert property (@(posedge clk) disable iff (!rst_n)
         !we[c] |=> $stable(map_q[c]));
   end
endmodule

// File: rtl/qtm_hit_detect.sv
module qtm_hit_detect #(
   parameter int NUM_CH = 8,
   parameter int KEY_W  = 12
) (
   input  logic                           probe,
   input  logic [KEY_W-1:0]               key,
   input  logic [NUM_CH-1:0][KEY_W-1:0]   map_q,
   output logic [NUM_CH-1:0]              hit
);
   // a zero map is a detached channel (R9)
   for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
      assign hit[c] = probe && (map_q[c] != '0) && (map_q[c] == key);
   end
endmodule

// File: rtl/qtm_event_track.sv
module qtm_event_track #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] hit,
   input  logic [NUM_CH-1:0] en_set,
   input  logic [NUM_CH-1:0] en_clr,
   input  logic [NUM_CH-1:0] sec_clr,
   input  logic [NUM_CH-1:0] miss_clr,
   input  logic              evt_ack,
   output logic [NUM_CH-1:0] evt_req,
   output logic [NUM_CH-1:0] en_q,
   output logic [NUM_CH-1:0] sec_q,
   output logic [NUM_CH-1:0] miss_q
);
   logic [NUM_CH-1:0] fire, lost, retire;

   assign fire    = hit & en_q & ~sec_q;
   assign lost    = hit & en_q & sec_q;
   // lowest in-flight channel wins the request
   assign evt_req = sec_q & (~sec_q + NUM_CH'(1));
   assign retire  = evt_ack ? evt_req : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         sec_q  <= '0;
         miss_q <= '0;
      end else begin
         en_q   <= (en_q | en_set) & ~en_clr;
         sec_q  <= (sec_q & ~retire & ~sec_clr) | fire;
         miss_q <= (miss_q & ~miss_clr) | lost;
      end
   end

   a_r5_req_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt_req));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      a_r5_fire_sets : assert property (@(posedge clk) disable iff (!rst_n)
         hit[c] && en_q[c] && !sec_q[c] |=> sec_q[c]);
      a_r4_disabled_quiet : assert property (@(posedge clk) disable iff (!rst_n)
         hit[c] && !en_q[c] && !sec_q[c] |=> !sec_q[c]);
      a_r7_missed_flag : assert property (@(posedge clk) disable iff (!rst_n)
         hit[c] && en_q[c] && sec_q[c] |=> miss_q[c]);
      a_r6_ack_retires : assert property (@(posedge clk) disable iff (!rst_n)
         evt_ack && evt_req[c] |=> !sec_q[c]);
      a_r8_miss_sticky : assert property (@(posedge clk) disable iff (!rst_n)
         miss_q[c] && !miss_clr[c] |=> miss_q[c]);
   end
endmodule

// File: rtl/qch_trigger_mapper.sv
module qch_trigger_mapper
   import qtm_pkg::*;
#(
   parameter int          NUM_CH    = 8,
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 32,
   parameter int          SLOT_W    = 9,
   parameter int          WORD_W    = 3,
   parameter int unsigned SLOT_BASE = 32'h4000,
   parameter int unsigned CTRL_BASE = 32'h0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              evt_ack,
   output logic [NUM_CH-1:0] evt_req,
   output logic [NUM_CH-1:0] en_mask,
   output logic [NUM_CH-1:0] sec_mask,
   output logic [NUM_CH-1:0] miss_mask
);
   localparam int KEY_W      = SLOT_W + WORD_W;
   localparam int REGION_LSB = WORD_LSB + KEY_W;
   localparam int TAG_W      = ADDR_W - REGION_LSB;
   localparam logic [TAG_W-1:0] REGION_TAG = TAG_W'(SLOT_BASE >> REGION_LSB);

   // elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("NUM_CH must lie in 1..DATA_W");
   end
   if (REGION_LSB > DATA_W) begin : g_bad_key
      $error("map field does not fit the data bus");
   end
   if (ADDR_W <= REGION_LSB) begin : g_bad_addr
      $error("address bus too narrow for the slot region");
   end
   if ((SLOT_BASE % (32'd1 << REGION_LSB)) != 0) begin : g_bad_align
      $error("SLOT_BASE must be aligned to the region size");
   end
   if ((CTRL_BASE >> REGION_LSB) == (SLOT_BASE >> REGION_LSB)) begin : g_bad_overlap
      $error("control registers overlap the slot region");
   end

   logic                          probe;
   logic [KEY_W-1:0]              wr_key;
   logic [NUM_CH-1:0]             ch_bits;
   logic [NUM_CH-1:0]             map_we;
   logic [NUM_CH-1:0][KEY_W-1:0]  map_q;
   logic [NUM_CH-1:0]             hit;
   logic                          sel_en_set, sel_en_clr, sel_sec_clr, sel_miss_clr;
   logic                          unused_data;

   assign probe   = wr_en && (wr_addr[ADDR_W-1:REGION_LSB] == REGION_TAG);
   assign wr_key  = wr_addr[REGION_LSB-1:WORD_LSB];
   assign ch_bits = wr_data[NUM_CH-1:0];
   assign unused_data = ^wr_data;

   assign sel_en_set   = wr_en && (wr_addr == ADDR_W'(CTRL_BASE + OFS_EN_SET));
   assign sel_en_clr   = wr_en && (wr_addr == ADDR_W'(CTRL_BASE + OFS_EN_CLR));
   assign sel_sec_clr  = wr_en && (wr_addr == ADDR_W'(CTRL_BASE + OFS_SEC_CLR));
   assign sel_miss_clr = wr_en && (wr_addr == ADDR_W'(CTRL_BASE + OFS_MISS_CLR));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign map_we[c] = wr_en && (wr_addr == ADDR_W'(CTRL_BASE + OFS_MAP0 + 4 * c));
   end

   qtm_map_regs #(.NUM_CH(NUM_CH), .KEY_W(KEY_W)) u_maps (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (map_we),
      .wkey  (wr_data[REGION_LSB-1:WORD_LSB]),
      .map_q (map_q)
   );

   qtm_hit_detect #(.NUM_CH(NUM_CH), .KEY_W(KEY_W)) u_hit (
      .probe (probe),
      .key   (wr_key),
      .map_q (map_q),
      .hit   (hit)
   );

   qtm_event_track #(.NUM_CH(NUM_CH)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .en_set   (sel_en_set   ? ch_bits : '0),
      .en_clr   (sel_en_clr   ? ch_bits : '0),
      .sec_clr  (sel_sec_clr  ? ch_bits : '0),
      .miss_clr (sel_miss_clr ? ch_bits : '0),
      .evt_ack  (evt_ack),
      .evt_req  (evt_req),
      .en_q     (en_mask),
      .sec_q    (sec_mask),
      .miss_q   (miss_mask)
   );

   // R10: nothing outside the slot region can reach the flags
   a_r10_no_stray_hit : assert property (@(posedge clk) disable iff (!rst_n)
      !probe |-> (hit == '0));
endmodule

// File: tb/qch_trigger_mapper_bench.sv
module qch_trigger_mapper_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        evt_ack = 1'b0;
   logic [7:0]  evt_req, en_mask, sec_mask, miss_mask;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   // requirement model
   logic [11:0] map_m [8];
   logic [7:0]  en_m = '0, sec_m = '0, miss_m = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qch_trigger_mapper u_qch_trigger_mapper (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .evt_ack(evt_ack), .evt_req(evt_req),
      .en_mask(en_mask), .sec_mask(sec_mask), .miss_mask(miss_mask)
   );

   function automatic logic [7:0] lowest(input logic [7:0] v);
      return v & (~v + 8'd1);
   endfunction

   function automatic logic [15:0] trig_addr(input int slot, input int word);
      return 16'(32'h4000 + 32 * slot + 4 * word);
   endfunction

   function automatic logic [31:0] map_val(input int slot, input int word);
      return 32'((slot << 5) | (word << 2));
   endfunction

   task automatic push(input string tag);
      exp_q.push_back({lowest(sec_m), en_m, sec_m, miss_m});
      tag_q.push_back(tag);
   endtask

   task automatic model_write(input logic [15:0] a, input logic [31:0] d);
      logic [7:0] s0;
      s0 = sec_m;
      if (a >= 16'h4000 && a <= 16'h7FFF) begin
         for (int c = 0; c < 8; c++)
            if (map_m[c] != 12'd0 && map_m[c] == a[13:2] && en_m[c]) begin
               if (s0[c]) miss_m[c] = 1'b1;
               else       sec_m[c]  = 1'b1;
            end
      end
      for (int c = 0; c < 8; c++)
         if (a == 16'(16'h0100 + 4 * c)) map_m[c] = d[13:2];
      if (a == 16'h0120) en_m   = en_m | d[7:0];
      if (a == 16'h0124) en_m   = en_m & ~d[7:0];
      if (a == 16'h0128) sec_m  = sec_m & ~d[7:0];
      if (a == 16'h012C) miss_m = miss_m & ~d[7:0];
   endtask

   // driver: one bus write, then post the expected state
   task automatic bus_wr(input logic [15:0] a, input logic [31:0] d, input string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      model_write(a, d);
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      push(tag);
   endtask

   task automatic ack_once(input string tag);
      @(negedge clk);
      evt_ack = 1'b1;
      sec_m = sec_m & ~lowest(sec_m);
      @(negedge clk);
      evt_ack = 1'b0;
      push(tag);
   endtask

   // monitor: compare the ports against each posted item
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            logic [31:0] e, got;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            got = {evt_req, en_mask, sec_mask, miss_mask};
            n_checks++;
            if (got !== e) begin
               n_fail++;
               $display("FAIL %s: req/en/sec/miss actual %h expected %h", t, got, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 8; c++) map_m[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      push("R1 reset state");

      bus_wr(16'h0100, map_val(5, 7),   "R2 map ch0");
      bus_wr(16'h010C, map_val(5, 7),   "R11 map ch3 same word");
      bus_wr(16'h0114, map_val(511, 0), "R2 map ch5 last slot");
      bus_wr(16'h0120, 32'h0000_0029,   "R3 enable set ch0 ch3 ch5");
      bus_wr(16'h0124, 32'h0000_0008,   "R3 enable clear ch3 only");
      bus_wr(trig_addr(5, 7), 32'h1,    "R5 trigger ch0, R4 ch3 disabled");
      bus_wr(trig_addr(5, 7), 32'h2,    "R7 retrigger in flight is missed");
      bus_wr(16'h0120, 32'h0000_0008,   "R3 enable set ch3");
      bus_wr(trig_addr(5, 7), 32'h3,    "R11 shared word, ch3 fires, ch0 missed");
      ack_once("R6 ack ch0, ch3 requested");
      ack_once("R6 ack ch3, idle");
      ack_once("R6 ack with nothing pending");
      bus_wr(trig_addr(5, 6), 32'h4,    "R10 neighbour word");
      bus_wr(trig_addr(4, 7), 32'h5,    "R10 neighbour slot");
      bus_wr(16'h3FFC, 32'h6,           "R10 below slot region");
      bus_wr(16'h0120, 32'h0000_0002,   "R3 enable set ch1");
      bus_wr(trig_addr(0, 0), 32'h7,    "R9 detached channel ignores slot0 word0");
      bus_wr(trig_addr(511, 0), 32'h8,  "R2 last slot triggers ch5");
      bus_wr(trig_addr(5, 7), 32'h9,    "R11 ch0 and ch3 fire together");
      ack_once("R5 lowest first, ch0 retired");
      bus_wr(16'h0128, 32'h0000_0020,   "R8 in-flight clear ch5");
      bus_wr(16'h012C, 32'h0000_0001,   "R8 missed clear ch0");
      bus_wr(16'h0100, 32'h0,           "R9 detach ch0");
      bus_wr(trig_addr(5, 7), 32'hA,    "R9 detached ch0 silent, R7 ch3 missed");
      bus_wr(16'h012C, 32'h0000_00FF,   "R8 missed clear all");

      @(negedge clk);
      wait (exp_q.size() == 0);
      @(negedge clk);
      #2;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule